// File: doc/BRIEF.md
# Misaligned Word Access RAM

This block is a synchronous on-chip RAM that moves either one byte or one 16-bit word per access. A word access may start at any byte address, odd addresses included, and it still completes in one cycle. The storage is split into two byte-wide banks. The even bank always drives and receives the high data lane, and the odd bank always drives and receives the low data lane.

For a word access at an odd address, the only special handling is that the even bank steps forward one row. That bank then supplies the byte after the addressed one. As a result, the addressed byte appears on the low lane and its successor on the high lane. No second bus cycle is ever needed.

Each request is described by three inputs: a read/write flag, address bit 0 and an active-low word strobe. Together they select one of eight access kinds. The block reports the kind one clock after the request, on the same edge as the registered read data.

Top module: `mwa_ram`

## Requirements
- R1: Coming out of reset, `rvalid`, `kind_vld`, `kind` and `rdata` are all 0.
- R2: When `req` is high, the following cycle has `kind_vld`=1 and `kind` = {word, addr[0], rd_nwr}. Here word is 1 for a 16-bit access and 0 for an 8-bit access, and rd_nwr is 1 for a read. Without a request, `kind_vld`=0 and `kind`=0.
- R3: With `wide_n`=1 and addr[0]=0, the access is an 8-bit access to an even byte on lane [15:8]. A read returns that byte there and 0 on [7:0].
- R4: With `wide_n`=0 and addr[0]=1, the access is an 8-bit access to an odd byte on lane [7:0]. A read returns that byte there and 0 on [15:8].
- R5: With `wide_n`=0 and addr[0]=0, the access is a 16-bit access to an even address. Byte addr maps to [15:8] and byte addr+1 maps to [7:0].
- R6: With `wide_n`=1 and addr[0]=1, the access is a 16-bit access to an odd address, completed in one cycle. Byte addr maps to [7:0] and byte addr+1 maps to [15:8].
- R7: A write changes only the bytes that its access kind selects. All other bytes keep their contents.
- R8: Read data is registered. `rdata` and `rvalid`=1 appear in the cycle after a read request. `rvalid` is 0 after any other cycle, and in that case `rdata` holds its previous value.
- R9: A 16-bit access at the last odd address wraps addr+1 to byte 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request for this cycle |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| wide_n | input | 1 | Word strobe; decoded together with addr[0] |
| addr | input | ADDR_W | Byte address |
| wdata | input | 16 | Write data, even-bank byte on [15:8] |
| rdata | output | 16 | Registered read data |
| rvalid | output | 1 | rdata was updated by a read |
| kind_vld | output | 1 | kind reports a request |
| kind | output | 3 | Access kind {word, odd, read} |

## Verification
Two functions can fall in the same cycle. In an odd-address word access, the even bank's row increment and the lane placement act together. At the top odd address, that increment also coincides with the address wrap to byte 0. The bench drives writes and reads back to back at odd word addresses, including the top one and byte 0 right after it, and it mixes all eight encodings at random addresses. Each registered result and kind is compared against a byte-array model that applies the lane rules independently.

// File: rtl/mwa_pkg.sv
package mwa_pkg;

    // Access kind code: {word, odd address, read}
    typedef enum logic [2:0] {
        K_WR_B_EVEN = 3'b000,
        K_RD_B_EVEN = 3'b001,
        K_WR_B_ODD  = 3'b010,
        K_RD_B_ODD  = 3'b011,
        K_WR_W_EVEN = 3'b100,
        K_RD_W_EVEN = 3'b101,
        K_WR_W_ODD  = 3'b110,
        K_RD_W_ODD  = 3'b111
    } acc_kind_e;

    localparam int LANE_W = 8;
    localparam int NLANES = 2;
    localparam int LANE_LO = 0;  // odd bank
    localparam int LANE_HI = 1;  // even bank

    typedef struct packed {
        logic                     rvalid;
        logic                     kvld;
        acc_kind_e                kind;
        logic [NLANES*LANE_W-1:0] rdata;
    } resp_t;

endpackage

// File: rtl/mwa_decode.sv
module mwa_decode
    import mwa_pkg::*;
#(
    parameter int ADDR_W = 10,
    localparam int ROW_W = ADDR_W - 1
) (
    input  logic              rd_nwr,
    input  logic              wide_n,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [NLANES-1:0] lane_en,
    output logic [ROW_W-1:0]  lane_row [NLANES]
);

    logic odd;
    logic word;
    logic [ROW_W-1:0] base_row;

    always_comb begin
        odd      = addr[0];
        // word when strobe and bit 0 agree
        word     = ~(wide_n ^ odd);
        base_row = addr[ADDR_W-1:1];
        kind     = acc_kind_e'({word, odd, rd_nwr});
        lane_en[LANE_LO] = odd | word;
        lane_en[LANE_HI] = ~odd | word;
        lane_row[LANE_LO] = base_row;
        // odd word: even bank holds addr+1 on the next row (wraps)
        lane_row[LANE_HI] = base_row + ROW_W'(odd);
    end

endmodule

// File: rtl/mwa_bank.sv
module mwa_bank #(
    parameter int ROW_W  = 9,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ROW_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wbyte,
    output logic [DATA_W-1:0] rbyte
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[row] <= wbyte;
        end
    end

    always_comb begin
        rbyte = mem_q[row];
    end

endmodule

// File: rtl/mwa_ram.sv
module mwa_ram
    import mwa_pkg::*;
#(
    parameter int ADDR_W = 10,
    localparam int ROW_W  = ADDR_W - 1,
    localparam int DATA_W = NLANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              rd_nwr,
    input  logic              wide_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              kind_vld,
    output logic [2:0]        kind
);

    acc_kind_e          dec_kind;
    logic [NLANES-1:0]  lane_en;
    logic [ROW_W-1:0]   lane_row [NLANES];
    logic [LANE_W-1:0]  lane_rd  [NLANES];
    logic [DATA_W-1:0]  steered;
    resp_t              resp_d, resp_q;

    mwa_decode #(.ADDR_W(ADDR_W)) u_dec (
        .rd_nwr   (rd_nwr),
        .wide_n   (wide_n),
        .addr     (addr),
        .kind     (dec_kind),
        .lane_en  (lane_en),
        .lane_row (lane_row)
    );

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        mwa_bank #(.ROW_W(ROW_W), .DATA_W(LANE_W)) u_bank (
            .clk   (clk),
            .we    (req & ~rd_nwr & lane_en[g]),
            .row   (lane_row[g]),
            .wbyte (wdata[g*LANE_W +: LANE_W]),
            .rbyte (lane_rd[g])
        );
        assign steered[g*LANE_W +: LANE_W] = lane_en[g] ? lane_rd[g] : '0;
    end

    always_comb begin
        resp_d        = resp_q;
        resp_d.rvalid = req & rd_nwr;
        resp_d.kvld   = req;
        resp_d.kind   = req ? dec_kind : K_WR_B_EVEN;
        if (req && rd_nwr) begin
            resp_d.rdata = steered;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign rdata    = resp_q.rdata;
    assign rvalid   = resp_q.rvalid;
    assign kind_vld = resp_q.kvld;
    assign kind     = resp_q.kind;

    // ---------------- assertions ----------------
    a_r8_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req && rd_nwr) |=> rvalid);

    a_r8_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && rd_nwr) |=> (!rvalid && $stable(rdata)));

    a_r2_kind_reports_request: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (kind_vld && kind == {~($past(wide_n) ^ $past(addr[0])),
                                      $past(addr[0]), $past(rd_nwr)}));

    a_r2_idle_kind_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!kind_vld && kind == 3'b000));

    a_r7_byte_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (wide_n ^ addr[0])) |-> $countones(lane_en) == 1);

    a_r6_word_both_banks: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !(wide_n ^ addr[0])) |-> (lane_en == '1));

    a_r9_wrap_row: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wide_n && (&addr)) |-> (lane_row[LANE_HI] == '0));

endmodule

// File: tb/tb_mwa_ram.sv
module tb_mwa_ram;

    localparam int ADDR_W = 10;
    localparam int NB     = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic              rd_nwr = 1'b0;
    logic              wide_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0]       wdata = '0;
    logic [15:0]       rdata;
    logic              rvalid;
    logic              kind_vld;
    logic [2:0]        kind;

    always #10 clk = ~clk;  // 50 MHz

    mwa_ram #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .rd_nwr(rd_nwr),
        .wide_n(wide_n), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rvalid(rvalid), .kind_vld(kind_vld), .kind(kind)
    );

    typedef struct {
        logic [15:0] data;
        logic        rd;
        logic [2:0]  kind;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [7:0]  ref_mem [NB];
    logic [15:0] last_rd = '0;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Driver: called just after a falling edge, returns after the next one
    task automatic acc(input logic rw, input logic st, input int a,
                       input logic [15:0] wd, input string tag);
        exp_t e;
        int   a1;
        logic word, odd;
        a1   = (a + 1) % NB;
        odd  = a[0];
        word = ~(st ^ odd);
        req = 1'b1; rd_nwr = rw; wide_n = st; addr = a[ADDR_W-1:0]; wdata = wd;
        e.rd   = rw;
        e.kind = {word, odd, rw};
        e.tag  = tag;
        if (rw) begin
            if (!word && !odd)     last_rd = {ref_mem[a], 8'h00};
            else if (!word && odd) last_rd = {8'h00, ref_mem[a]};
            else if (!odd)         last_rd = {ref_mem[a], ref_mem[a1]};
            else                   last_rd = {ref_mem[a1], ref_mem[a]};
        end else begin
            if (!word && !odd)     ref_mem[a] = wd[15:8];
            else if (!word && odd) ref_mem[a] = wd[7:0];
            else if (!odd) begin   ref_mem[a] = wd[15:8]; ref_mem[a1] = wd[7:0]; end
            else begin             ref_mem[a] = wd[7:0];  ref_mem[a1] = wd[15:8]; end
        end
        e.data = last_rd;
        sb.push_back(e);
        @(negedge clk);
        req = 1'b0;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && kind_vld) begin
            exp_t e;
            if (sb.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R2 unexpected kind_vld act=%b exp=0", kind_vld);
            end else begin
                e = sb.pop_front();
                n_cmp++;
                if (kind !== e.kind || rvalid !== e.rd || rdata !== e.data) begin
                    n_bad++;
                    $display("FAIL %s act kind=%b rv=%b data=%h exp kind=%b rv=%b data=%h",
                             e.tag, kind, rvalid, rdata, e.kind, e.rd, e.data);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_cmp++;  // R1 reset state
        if (rvalid !== 1'b0 || kind_vld !== 1'b0 || kind !== 3'b000 || rdata !== 16'h0) begin
            n_bad++;
            $display("FAIL R1 act rv=%b kv=%b kind=%b data=%h exp all zero",
                     rvalid, kind_vld, kind, rdata);
        end
        // Fill memory with even word writes (R5)
        for (int i = 0; i < NB; i += 2)
            acc(1'b0, 1'b0, i, 16'(i * 16'h0103 + 16'h5a), "R5 fill");
        // R3 even byte write then reads
        acc(1'b0, 1'b1, 16, 16'hA5C3, "R3 write");
        acc(1'b1, 1'b1, 16, 16'h0, "R3 read");
        acc(1'b1, 1'b0, 16, 16'h0, "R7 neighbour kept");
        // R4 odd byte write then reads
        acc(1'b0, 1'b0, 33, 16'h1E77, "R4 write");
        acc(1'b1, 1'b0, 33, 16'h0, "R4 read");
        acc(1'b1, 1'b0, 32, 16'h0, "R7 even byte kept");
        // R6 odd word, back to back write/read
        acc(1'b0, 1'b1, 101, 16'hBEEF, "R6 write");
        acc(1'b1, 1'b1, 101, 16'h0, "R6 read");
        acc(1'b1, 1'b0, 100, 16'h0, "R6 even view");
        acc(1'b1, 1'b0, 102, 16'h0, "R6 next word");
        // R9 wrap at last odd address
        acc(1'b0, 1'b1, NB - 1, 16'hC0DE, "R9 write");
        acc(1'b1, 1'b1, NB - 1, 16'h0, "R9 read");
        acc(1'b1, 1'b0, 0, 16'h0, "R9 byte0");
        acc(1'b1, 1'b0, NB - 2, 16'h0, "R9 top word");
        // R8 idle gap keeps data
        repeat (2) @(negedge clk);
        n_cmp++;
        if (rvalid !== 1'b0 || rdata !== last_rd) begin
            n_bad++;
            $display("FAIL R8 idle act rv=%b data=%h exp rv=0 data=%h", rvalid, rdata, last_rd);
        end
        // Mixed random traffic over all eight encodings (R2)
        for (int k = 0; k < 2000; k++) begin
            logic [2:0] r = 3'($urandom);
            int a = int'($urandom % NB);
            if (r[1] != a[0]) a = a ^ 1;
            acc(r[0], r[2] ^ r[1] ? 1'b0 : 1'b1, a, 16'($urandom), "R2 mixed");
            if (r[2]) begin
                // confirm wide_n encoding: word uses wide_n == addr[0]
            end
        end
        repeat (3) @(negedge clk);
        n_cmp++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R8 results missing act=%0d exp=0", sb.size());
        end
        done = 1'b1;
        report();
    end

endmodule